// File: doc/BRIEF.md
# Converter Cycle Serial Output Controller

This block sequences the digital output side of a delta-sigma converter. It runs a fixed loop of three phases: a timed conversion, a sleep phase that holds the result, and a serial read phase. When the conversion timer expires, the block takes one result word from a stubbed conversion engine on `result_in`. It keeps that word unchanged for as long as the host leaves chip select high.

A host reads the word over a three-wire link: an active-low chip select, a serial clock and a serial data output. Pulling chip select low during sleep starts the read. The most significant bit appears at once, and each later bit appears after a falling serial-clock edge, so the host samples on rising edges. The read ends after the full word, or earlier when chip select is released. Either way a new conversion starts straight away, so every word read belongs to the conversion that has just finished.

Chip select and serial clock reach the block from outside its clock. Each passes through a synchronizer, and serial-clock edges are found on the synchronized copy.

Top module: `csc_top`

## Requirements
- R1: After reset the block is converting: `busy` is 1 and `sdo` is at the idle level.
- R2: A conversion lasts exactly CONV_CYCLES system clocks from reset release (`busy` high), after which the block sleeps with `busy` low for as long as `cs_n` stays high, with no time limit.
- R3: While sleeping, the captured word stays unchanged whatever `result_in` does.
- R4: `cs_n` low during sleep starts output; the word's most significant bit appears on `sdo` within four system clocks, before any serial-clock edge.
- R5: During output, `sdo` changes only after a falling `sclk` edge and stays stable while `sclk` is high.
- R6: After WORD_W falling `sclk` edges the output ends and a new conversion starts (`busy` goes 1) even though `cs_n` is still low.
- R7: `cs_n` going high during output aborts it at once: `sdo` returns to the idle level and a new conversion starts.
- R8: Each word shifted out equals `result_in` as sampled at the end of the conversion just finished, never an earlier one.
- R9: `cs_n` low during a conversion does not shorten it; `sdo` stays idle until the conversion ends, and output then begins on its own if `cs_n` is still low.
- R10: Whenever the block is not outputting, `sdo` equals IDLE_LEVEL (default 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| result_in | input | WORD_W | Result word from the conversion engine stub |
| sdo | output | 1 | Serial data out, MSB first |
| busy | output | 1 | High while a conversion is in progress |

## Verification
The hardest situation to reach from the ports is a chip-select request that arrives while a conversion is running and is still pending when the conversion ends. The bench finishes a full read and leaves `cs_n` low through the next conversion. It checks that `sdo` stays idle while `busy` is high, and that output then starts by itself with the new word. Aborts part way through a word and long sleeps with a changing `result_in` are driven as well. A walking-one sweep over all bit positions exposes any error in bit order or in the bit count.

// File: rtl/csc_pkg.sv
package csc_pkg;
   typedef enum logic [1:0] {
      ST_CONVERT = 2'd0,
      ST_SLEEP   = 2'd1,
      ST_OUTPUT  = 2'd2
   } cyc_state_e;
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("csc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gi] <= RST_VAL;
            else if (gi == 0) chain[gi] <= d;
            else chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/csc_timer.sv
module csc_timer #(
   parameter int CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   generate
      if (CYCLES < 2) begin : g_bad
         $error("csc_timer: CYCLES must be at least 2");
      end
   endgenerate

   localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES-1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (!run || done) cnt <= '0;
      else cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LAST);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < CYCLES); // R2
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0); // R2
endmodule

// File: rtl/csc_shifter.sv
module csc_shifter #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] din,
   input  logic              shift,
   output logic              msb
);
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (load) word_q <= din;
      else if (shift) word_q <= {word_q[WORD_W-2:0], 1'b0};
   end

   assign msb = word_q[WORD_W-1];

   AST_HOLD_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(word_q)); // R3
endmodule

// File: rtl/csc_top.sv
module csc_top #(
   parameter int WORD_W      = 32,
   parameter int CONV_CYCLES = 64,
   parameter int SYNC_STAGES = 2,
   parameter bit IDLE_LEVEL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic [WORD_W-1:0] result_in,
   output logic              sdo,
   output logic              busy
);
   import csc_pkg::*;

   generate
      if (WORD_W < 2) begin : g_bad_w
         $error("csc_top: WORD_W must be at least 2");
      end
   endgenerate

   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W-1);

   logic cs_s, sck_s, sck_prev, sck_fall;
   logic conv_done, shifter_msb;
   logic [BIT_W-1:0] bcnt;
   cyc_state_e st_q;

   csc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   csc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sck_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else sck_prev <= sck_s;
   end
   assign sck_fall = sck_prev && !sck_s;

   csc_timer #(.CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st_q == ST_CONVERT), .done(conv_done));

   csc_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(conv_done), .din(result_in),
      .shift((st_q == ST_OUTPUT) && sck_fall), .msb(shifter_msb));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_CONVERT;
         bcnt <= '0;
      end else begin
         case (st_q)
            ST_CONVERT: if (conv_done) st_q <= ST_SLEEP;
            ST_SLEEP: if (!cs_s) begin
               st_q <= ST_OUTPUT;
               bcnt <= '0;
            end
            ST_OUTPUT: begin
               if (cs_s) st_q <= ST_CONVERT;
               else if (sck_fall) begin
                  if (bcnt == LAST_BIT) st_q <= ST_CONVERT;
                  bcnt <= bcnt + 1'b1;
               end
            end
            default: st_q <= ST_CONVERT;
         endcase
      end
   end

   assign sdo  = (st_q == ST_OUTPUT) ? shifter_msb : IDLE_LEVEL;
   assign busy = (st_q == ST_CONVERT);

   AST_CONV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CONVERT) |=> (st_q == ST_CONVERT || st_q == ST_SLEEP)); // R1
   AST_SLEEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SLEEP) |=> (st_q == ST_SLEEP || st_q == ST_OUTPUT)); // R4
   AST_OUT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OUTPUT) |=> (st_q == ST_OUTPUT || st_q == ST_CONVERT)); // R6
   AST_SLEEP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SLEEP && cs_s) |=> (st_q == ST_SLEEP)); // R2
   AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OUTPUT && cs_s) |=> (st_q == ST_CONVERT)); // R7
   AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OUTPUT && !sck_fall && !cs_s) |=> $stable(sdo)); // R5
   AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CONVERT && !conv_done) |=> (st_q == ST_CONVERT)); // R9
endmodule

// File: tb/csc_top_bench.sv
module csc_top_bench;
   localparam int W = 32;
   localparam int C = 20;
   localparam int HP = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic [W-1:0] result_in = '0;
   logic sdo, busy;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   csc_top #(.WORD_W(W), .CONV_CYCLES(C), .SYNC_STAGES(2), .IDLE_LEVEL(1'b1)) u_csc_top (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
      .result_in(result_in), .sdo(sdo), .busy(busy));

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_sleep();
      int guard = 0;
      while (busy && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      chk(!busy, "R2 conversion ends", W'(busy), '0);
   endtask

   // read nbits bits of exp; leaves cs_n low
   task automatic read_bits(input int nbits, input logic [W-1:0] exp, input string req);
      bit ok = 1'b1;
      bit stable_ok = 1'b1;
      logic [W-1:0] got = '0;
      cs_n = 1'b0;
      clks(4);
      for (int i = 0; i < nbits; i++) begin
         logic b;
         b = sdo;
         got[W-1-i] = b;
         if (b !== exp[W-1-i]) ok = 1'b0;
         sclk = 1'b1;
         clks(HP / 2);
         if (sdo !== b) stable_ok = 1'b0;
         clks(HP - HP / 2);
         if (sdo !== b) stable_ok = 1'b0;
         sclk = 1'b0;
         clks(HP);
      end
      chk(ok, req, got, exp);
      chk(stable_ok, "R5 sdo stable while sclk high", W'(stable_ok), W'(1));
   endtask

   initial begin
      logic [W-1:0] cur;
      logic [W-1:0] pat;
      int k;
      result_in = 32'hC0FFEE11;
      clks(3);
      chk(busy === 1'b1, "R1 busy in reset", W'(busy), W'(1));
      chk(sdo === 1'b1, "R1 sdo idle in reset", W'(sdo), W'(1));
      rst_n = 1'b1;
      k = 0;
      while (busy && k < 1000) begin
         k++;
         @(negedge clk);
      end
      chk(k == C, "R2 conversion length", W'(k), W'(C));
      cur = 32'hC0FFEE11;

      // R2/R3/R10: long sleep with changing input
      for (int i = 0; i < 40; i++) begin
         result_in = 32'h1234_0000 + 32'(i * 977);
         clks(13);
      end
      chk(busy === 1'b0, "R2 stays asleep", W'(busy), '0);
      chk(sdo === 1'b1, "R10 sdo idle in sleep", W'(sdo), W'(1));
      result_in = 32'hA5A5_5A5A;
      read_bits(W, cur, "R3 held word read out");
      clks(2);
      chk(busy === 1'b1, "R6 new conversion after full word", W'(busy), W'(1));
      chk(sdo === 1'b1, "R10 sdo idle after word", W'(sdo), W'(1));
      cs_n = 1'b1;
      wait_sleep();
      cur = 32'hA5A5_5A5A;

      // R8: walking-one sweep and arithmetic patterns
      for (int p = 0; p < W + 6; p++) begin
         if (p < W) pat = W'(1) << p;
         else pat = 32'(p * 32'h9E37_79B9) ^ 32'h0F0F_F0F0;
         read_bits(W, cur, "R8 word of last conversion");
         result_in = pat;
         clks(1);
         cs_n = 1'b1;
         wait_sleep();
         cur = pat;
      end
      result_in = 32'hFFFF_FFFF;
      read_bits(W, cur, "R8 word before all-ones");
      cs_n = 1'b1;
      wait_sleep();
      cur = 32'hFFFF_FFFF;
      result_in = 32'h0000_0000;
      read_bits(W, cur, "R8 all-ones word");

      // R9: cs_n held low through the next conversion
      k = 0;
      clks(2);
      while (busy) begin
         if (sdo !== 1'b1) k++;
         @(negedge clk);
      end
      chk(k == 0, "R9 sdo idle during conversion", W'(k), '0);
      clks(2);
      chk(sdo === 1'b0, "R9 output begins after conversion", W'(sdo), '0);
      read_bits(W, 32'h0000_0000, "R9 pending read word");
      cs_n = 1'b1;
      wait_sleep();

      // R7: abort after 10 bits
      cur = 32'h0000_0000;
      result_in = 32'h8BAD_F00D;
      read_bits(10, cur, "R7 partial word");
      cs_n = 1'b1;
      clks(4);
      chk(busy === 1'b1, "R7 abort starts conversion", W'(busy), W'(1));
      chk(sdo === 1'b1, "R7 sdo idle after abort", W'(sdo), W'(1));
      wait_sleep();
      result_in = 32'h0;
      read_bits(W, 32'h8BAD_F00D, "R7 word after abort");
      cs_n = 1'b1;
      clks(4);

      // R4: first bit before any sclk edge
      wait_sleep();
      cs_n = 1'b0;
      clks(4);
      chk(sdo === 1'b0 && busy === 1'b0, "R4 msb on cs_n fall", W'(sdo), '0);
      cs_n = 1'b1;
      clks(4);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule